// File: doc/BRIEF.md
# Fully Associative Translation Cache

This block holds a small set of recent virtual-page-to-frame translations in front of a page table walker. Each lookup compares the requested virtual page number with every valid entry at once. When one entry matches, the block returns that entry's frame number and permission bits in the same cycle. It also checks the access type against those permissions and raises a protection fault when the access is not allowed. When no entry matches, the block raises a miss.

The walker answers a miss by presenting a fill. The fill writes the translation into a victim entry, which is chosen as follows:

- an entry that already holds the same page number, so that no page is ever stored twice;
- otherwise the lowest-numbered invalid entry;
- otherwise the entry named by a round-robin pointer.

A flush input clears every valid bit at once, so that a context switch leaves no stale translations behind.

Top module: `page_xlate_cache`

## Requirements
- R1: When `lu_valid` is high and a valid entry holds `lu_vpn`, `lu_hit` is high in the same cycle, and `lu_pfn` and `lu_perm` carry that entry's frame number and permissions.
- R2: When `lu_valid` is high and no valid entry holds `lu_vpn`, `lu_miss` is high and `lu_hit` is low. Whenever `lu_hit` is low, `lu_pfn`, `lu_perm` and `lu_fault` are zero. When `lu_valid` is low, both `lu_hit` and `lu_miss` are low.
- R3: A cycle with `flush` high makes every entry invalid from the next cycle onward, and it leaves the round-robin pointer unchanged.
- R4: Permission bits are encoded as bit 0 read, bit 1 write and bit 2 execute. `lu_acc` is encoded as 2'b00 read, 2'b01 write and 2'b10 execute, and 2'b11 is never permitted. On a hit whose access type is not permitted, `lu_fault` is high.
- R5: A fill with `flush` low is written to a victim entry. The victim is the entry already holding `fill_vpn` if there is one. Otherwise it is the lowest-numbered invalid entry. Otherwise it is the entry at the round-robin pointer.
- R6: The round-robin pointer starts at 0 and advances by one, wrapping after the last entry, on every fill that is written. It holds its value in all other cycles.
- R7: When `flush` and `fill_valid` are high in the same cycle, the fill is discarded and the flush takes effect.
- R8: A lookup in the same cycle as a fill sees the contents from before the fill. The new translation can be hit from the next cycle onward.
- R9: After reset, every entry is invalid and the round-robin pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| lu_valid | input | 1 | Lookup request |
| lu_vpn | input | VPN_W | Virtual page number to translate |
| lu_acc | input | 2 | Access type of the lookup |
| lu_hit | output | 1 | A valid entry matched |
| lu_miss | output | 1 | No valid entry matched |
| lu_pfn | output | PFN_W | Frame number on a hit |
| lu_perm | output | 3 | Permissions on a hit |
| lu_fault | output | 1 | Hit with an access type that is not permitted |
| fill_valid | input | 1 | Install a translation from the walker |
| fill_vpn | input | VPN_W | Page number of the fill |
| fill_pfn | input | PFN_W | Frame number of the fill |
| fill_perm | input | 3 | Permissions of the fill |

## Verification
The assertions check several properties on every cycle:

- hit and miss are never both high, and a lookup always produces one of them;
- a fault occurs only on a hit;
- at most one entry matches any lookup;
- a flush empties the table;
- the pointer moves only on an accepted fill.

Victim selection, the independence of same-cycle lookups from fills, and the flush-over-fill priority can only be shown by the bench's scenarios. The bench compares every output with its reference model on each cycle, with the reference model tracking the table contents. The scenarios fill the table, force pointer-based replacement, refill a page that is already present, and collide a flush with a fill.

// File: rtl/page_xlate_cache.sv
module page_xlate_cache #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             lu_valid,
  input  logic [VPN_W-1:0] lu_vpn,
  input  logic [1:0]       lu_acc,
  output logic             lu_hit,
  output logic             lu_miss,
  output logic [PFN_W-1:0] lu_pfn,
  output logic [2:0]       lu_perm,
  output logic             lu_fault,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic [2:0]       fill_perm
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] ent_valid;
  logic [VPN_W-1:0]   ent_vpn  [ENTRIES];
  logic [PFN_W-1:0]   ent_pfn  [ENTRIES];
  logic [2:0]         ent_perm [ENTRIES];
  logic [IDX_W-1:0]   rr_ptr;

  logic [ENTRIES-1:0] lu_match, fl_match;
  logic [PFN_W-1:0]   sel_pfn;
  logic [2:0]         sel_perm;
  logic               fl_hit, free_any, do_fill, allowed;
  logic [IDX_W-1:0]   fl_idx, free_idx, victim;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign lu_match[g] = ent_valid[g] && (ent_vpn[g] == lu_vpn);
      assign fl_match[g] = ent_valid[g] && (ent_vpn[g] == fill_vpn);
    end
  endgenerate

  always_comb begin
    sel_pfn  = '0;
    sel_perm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      sel_pfn  = sel_pfn  | ({PFN_W{lu_match[i]}} & ent_pfn[i]);
      sel_perm = sel_perm | ({3{lu_match[i]}} & ent_perm[i]);
    end
  end

  always_comb begin
    case (lu_acc)
      2'b00:   allowed = sel_perm[0];
      2'b01:   allowed = sel_perm[1];
      2'b10:   allowed = sel_perm[2];
      default: allowed = 1'b0;
    endcase
  end

  assign lu_hit   = lu_valid && (|lu_match);
  assign lu_miss  = lu_valid && !(|lu_match);
  assign lu_pfn   = lu_hit ? sel_pfn  : '0;
  assign lu_perm  = lu_hit ? sel_perm : '0;
  assign lu_fault = lu_hit && !allowed;

  always_comb begin
    fl_hit   = 1'b0;
    fl_idx   = '0;
    free_any = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (fl_match[i]) begin
        fl_hit = 1'b1;
        fl_idx = IDX_W'(i);
      end
      if (!ent_valid[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign victim  = fl_hit ? fl_idx : (free_any ? free_idx : rr_ptr);
  assign do_fill = fill_valid && !flush;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_valid <= '0;
      rr_ptr    <= '0;
    end else if (flush) begin
      ent_valid <= '0;
    end else if (do_fill) begin
      ent_valid[victim] <= 1'b1;
      rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_fill) begin
      ent_vpn[victim]  <= fill_vpn;
      ent_pfn[victim]  <= fill_pfn;
      ent_perm[victim] <= fill_perm;
    end
  end
endmodule

// File: rtl/page_xlate_cache_chk.sv
module page_xlate_cache_chk #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush,
  input logic               fill_valid,
  input logic               lu_valid,
  input logic               lu_hit,
  input logic               lu_miss,
  input logic               lu_fault,
  input logic [ENTRIES-1:0] ent_valid,
  input logic [ENTRIES-1:0] lu_match,
  input logic [IDX_W-1:0]   rr_ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(lu_hit && lu_miss)); // R2
  AST_LOOKUP_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    lu_valid |-> (lu_hit || lu_miss)); // R1
  AST_FAULT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    lu_fault |-> lu_hit); // R4
  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lu_match) <= 1); // R5
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (ent_valid == '0)); // R3
  AST_FLUSH_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> $stable(rr_ptr)); // R7
  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !flush) |=>
      (rr_ptr == (($past(rr_ptr) == LAST) ? '0 : $past(rr_ptr) + 1'b1))); // R6
  AST_PTR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_valid |=> $stable(rr_ptr)); // R6
  AST_FILL_INSTALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !flush) |=> (ent_valid != '0)); // R5
endmodule

bind page_xlate_cache page_xlate_cache_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .fill_valid(fill_valid),
  .lu_valid(lu_valid), .lu_hit(lu_hit), .lu_miss(lu_miss), .lu_fault(lu_fault),
  .ent_valid(ent_valid), .lu_match(lu_match), .rr_ptr(rr_ptr)
);

// File: tb/tb_page_xlate_cache.sv
module tb_page_xlate_cache;
  localparam int N = 8;
  localparam int VW = 20;
  localparam int PW = 16;

  logic clk = 0, rst_n = 0;
  logic flush = 0, lu_valid = 0, fill_valid = 0;
  logic [VW-1:0] lu_vpn = '0, fill_vpn = '0;
  logic [PW-1:0] fill_pfn = '0;
  logic [1:0] lu_acc = '0;
  logic [2:0] fill_perm = '0;
  logic lu_hit, lu_miss, lu_fault;
  logic [PW-1:0] lu_pfn;
  logic [2:0] lu_perm;

  always #2 clk = ~clk;

  page_xlate_cache #(.ENTRIES(N), .VPN_W(VW), .PFN_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lu_valid(lu_valid), .lu_vpn(lu_vpn),
    .lu_acc(lu_acc), .lu_hit(lu_hit), .lu_miss(lu_miss), .lu_pfn(lu_pfn),
    .lu_perm(lu_perm), .lu_fault(lu_fault), .fill_valid(fill_valid),
    .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_perm(fill_perm));

  bit            mv [N];
  logic [VW-1:0] mvpn [N];
  logic [PW-1:0] mpfn [N];
  logic [2:0]    mperm [N];
  int mptr = 0;
  int vectors = 0, errors = 0;
  bit done = 0;

  function automatic int find(input logic [VW-1:0] v);
    for (int i = 0; i < N; i++) if (mv[i] && mvpn[i] == v) return i;
    return -1;
  endfunction

  task automatic step(input bit fl, input bit fv, input logic [VW-1:0] fvpn,
                      input logic [PW-1:0] fpfn, input logic [2:0] fperm,
                      input bit lv, input logic [VW-1:0] lvpn, input logic [1:0] acc,
                      input string tag);
    int k, v;
    bit eh, em, ef, ok;
    logic [PW-1:0] ep;
    logic [2:0] eperm;
    flush = fl; fill_valid = fv; fill_vpn = fvpn; fill_pfn = fpfn; fill_perm = fperm;
    lu_valid = lv; lu_vpn = lvpn; lu_acc = acc;
    #1;
    k = find(lvpn);
    eh = lv && (k >= 0);
    em = lv && (k < 0);
    ep = eh ? mpfn[k] : '0;
    eperm = eh ? mperm[k] : '0;
    case (acc)
      2'd0: ok = eperm[0];
      2'd1: ok = eperm[1];
      2'd2: ok = eperm[2];
      default: ok = 1'b0;
    endcase
    ef = eh && !ok;
    vectors++;
    if (lu_hit !== eh || lu_miss !== em || lu_pfn !== ep || lu_perm !== eperm || lu_fault !== ef) begin
      errors++;
      $display("FAIL %s vpn=%0h: hit/miss/pfn/perm/fault got %b/%b/%0h/%b/%b expected %b/%b/%0h/%b/%b",
               tag, lvpn, lu_hit, lu_miss, lu_pfn, lu_perm, lu_fault, eh, em, ep, eperm, ef);
    end
    @(posedge clk);
    if (fl) begin
      for (int i = 0; i < N; i++) mv[i] = 0;
    end else if (fv) begin
      v = find(fvpn);
      if (v < 0) for (int i = N - 1; i >= 0; i--) if (!mv[i]) v = i;
      if (v < 0) v = mptr;
      mv[v] = 1; mvpn[v] = fvpn; mpfn[v] = fpfn; mperm[v] = fperm;
      mptr = (mptr + 1) % N;
    end
    @(negedge clk);
  endtask

  task automatic look(input logic [VW-1:0] v, input logic [1:0] acc, input string tag);
    step(0, 0, '0, '0, '0, 1, v, acc, tag);
  endtask

  task automatic fill(input logic [VW-1:0] v, input logic [PW-1:0] p, input logic [2:0] pm,
                      input string tag);
    step(0, 1, v, p, pm, 0, '0, '0, tag);
  endtask

  initial begin
    for (int i = 0; i < N; i++) mv[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    look(20'h0, 2'd0, "R9 empty after reset");
    look(20'h12345, 2'd1, "R9 empty after reset");
    step(0, 0, '0, '0, '0, 0, 20'h5, 2'd0, "R2 idle lookup");
    for (int i = 0; i < N; i++) fill(20'h100 + 20'(i), 16'hA000 + 16'(i), 3'(i), "R5 fill free");
    for (int i = 0; i < N; i++) look(20'h100 + 20'(i), 2'(i % 3), "R1 R4 hit and perm");
    look(20'h103, 2'd3, "R4 reserved access faults");
    look(20'h999, 2'd0, "R2 miss");
    // Table full and pointer back to 0: this fill must replace entry 0.
    step(0, 1, 20'h200, 16'hBEEF, 3'b111, 1, 20'h200, 2'd0, "R8 same-cycle lookup sees old");
    look(20'h200, 2'd2, "R8 new entry visible");
    look(20'h100, 2'd0, "R6 pointer victim evicted");
    fill(20'h300, 16'h0300, 3'b001, "R6 pointer advance");
    look(20'h101, 2'd0, "R6 second pointer victim evicted");
    // A refill of a page already present overwrites it, with no duplicate.
    fill(20'h105, 16'h7777, 3'b010, "R5 overwrite existing");
    look(20'h105, 2'd1, "R5 overwrite existing");
    look(20'h105, 2'd0, "R4 read denied");
    // Flush and fill collide in one cycle.
    step(1, 1, 20'h400, 16'h4444, 3'b111, 1, 20'h102, 2'd0, "R7 flush wins");
    look(20'h400, 2'd0, "R7 discarded fill");
    look(20'h102, 2'd0, "R3 flushed");
    look(20'h200, 2'd0, "R3 flushed");
    fill(20'h500, 16'h5555, 3'b101, "R3 refill after flush");
    look(20'h500, 2'd2, "R3 refill after flush");
    for (int c = 0; c < 4000; c++) begin
      bit fl, fv, lv;
      fl = ($urandom % 40) == 0;
      fv = ($urandom % 3) == 0;
      lv = ($urandom % 4) != 0;
      step(fl, fv, 20'($urandom % 14), 16'($urandom), 3'($urandom), lv,
           20'($urandom % 14), 2'($urandom), "R1 R5 mixed traffic");
    end
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule